// File: doc/BRIEF.md
# Radix-4 Booth Sequential Signed Multiplier

This block multiplies two signed two's-complement operands over several clock cycles and returns a signed product twice as wide as the operands. On each working cycle it inspects a window of three multiplier bits: two new bits plus the last bit already consumed. It maps that window onto one digit from the set {-2, -1, 0, +1, +2}. It adds that multiple of the multiplicand into the upper part of a shifting accumulator, then shifts the whole accumulator right by two places while keeping the sign. A run of ones in the multiplier is handled as one subtraction where the run starts and one addition just past where it ends. This retires two multiplier bits per cycle, so a 32-bit multiply takes 16 working cycles.

The client pulses `start_i` while the block is idle, with both operands valid in that cycle. `busy_o` then stays high for the working cycles. `done_o` marks the single cycle in which the finished product is first visible. The product then stays on `product_o` until the next accepted start. The accumulator's lower half is loaded with the multiplier, and its bits are used up as product bits move in from above. The upper half is two bits wider than an operand, so twice the most negative multiplicand, and its negation, never overflow.

Top module: `booth4_mul`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: A `start_i` seen while `busy_o` is low is accepted at that clock edge. `busy_o` is then high for exactly W/2 cycles (16 for W=32), beginning with the cycle after the accepting edge.
- R3: `done_o` is high for exactly one cycle: the first cycle in which `busy_o` is low again after a multiply.
- R4: When `done_o` is high, `product_o` equals the signed product of the multiplicand and multiplier captured at the accepting edge, as a 2W-bit two's-complement value.
- R5: `start_i` and the operand inputs are ignored while `busy_o` is high. The running multiply's result and length are unchanged.
- R6: While `busy_o` is low and no start is accepted, `product_o` holds its value, and `done_o` stays low after its single pulse.
- R7: Each window {b[2i+1], b[2i], b[2i-1]}, with b[-1]=0, selects the digit: 000 and 111 give 0; 001 and 010 give +1; 011 gives +2; 100 gives -2; 101 and 110 give -1. Multipliers made of alternating bits and of runs of ones and zeros give exact products.
- R8: A multiplicand of -2^(W-1) gives exact products with every multiplier, including the cases where the digit is ±2.
- R9: A start in the same cycle as `done_o` is accepted, and the next multiply runs with its full length and correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a multiply; taken only when idle |
| mcand_i | input | W | Signed multiplicand, sampled on the accepting edge |
| mplier_i | input | W | Signed multiplier, sampled on the accepting edge |
| busy_o | output | 1 | High while the multiply is running |
| done_o | output | 1 | One-cycle marker that the product is ready |
| product_o | output | 2W | Signed product, held until the next accepted start |

## Verification
The assertions assume that `start_i` and both operands hold known values at every rising edge after reset. The checker's own reference product is built from the operands sampled in the cycle a start is accepted. It does not track the operands at later edges, so it relies on the design ignoring them while busy. The bench drives every input only on falling edges, keeps all inputs at defined values from time zero, and changes the operands while busy only to probe the ignore behaviour.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

  // Recoded radix-4 digit selected by one 3-bit multiplier window.
  typedef enum logic [2:0] {
    DIG_ZERO = 3'd0,
    DIG_POS1 = 3'd1,
    DIG_POS2 = 3'd2,
    DIG_NEG1 = 3'd3,
    DIG_NEG2 = 3'd4
  } booth_dig_e;

  function automatic logic dig_is_neg(booth_dig_e d);
    return (d == DIG_NEG1) || (d == DIG_NEG2);
  endfunction

  function automatic logic dig_is_two(booth_dig_e d);
    return (d == DIG_POS2) || (d == DIG_NEG2);
  endfunction

endpackage

// File: rtl/booth4_recoder.sv
module booth4_recoder
  import booth4_pkg::*;
(
  input  logic [2:0]  win_i,   // {upper bit, lower bit, bit to the right}
  output booth_dig_e  dig_o
);

  // R7: window to digit mapping
  always_comb begin
    unique case (win_i)
      3'b000:  dig_o = DIG_ZERO;
      3'b001:  dig_o = DIG_POS1;
      3'b010:  dig_o = DIG_POS1;
      3'b011:  dig_o = DIG_POS2;
      3'b100:  dig_o = DIG_NEG2;
      3'b101:  dig_o = DIG_NEG1;
      3'b110:  dig_o = DIG_NEG1;
      default: dig_o = DIG_ZERO;
    endcase
  end

endmodule

// File: rtl/booth4_addsub.sv
module booth4_addsub
  import booth4_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] mcand_i,
  input  logic [W+1:0] acc_i,
  input  booth_dig_e   dig_o_i,
  output logic [W+1:0] sum_o
);

  localparam int AW = W + 2;

  logic [AW-1:0] ext;
  logic [AW-1:0] mag;
  logic [AW-1:0] addend;
  logic          neg;

  // Two guard bits keep +/-2 x (-2^(W-1)) representable (R8).
  assign ext = {{2{mcand_i[W-1]}}, mcand_i};
  assign neg = dig_is_neg(dig_o_i);

  always_comb begin
    if (dig_o_i == DIG_ZERO) begin
      mag = '0;
    end else if (dig_is_two(dig_o_i)) begin
      mag = {ext[AW-2:0], 1'b0};
    end else begin
      mag = ext;
    end
  end

  assign addend = neg ? ~mag : mag;
  assign sum_o  = acc_i + addend + {{(AW-1){1'b0}}, neg};

endmodule

// File: rtl/booth4_ctrl.sv
module booth4_ctrl #(
  parameter int STEPS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic load_o,
  output logic step_o
);

  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(STEPS - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n;
  logic          done_q, done_n;
  logic          last;
  logic          cnt_en;

  assign load_o = start_i && !busy_q;   // R5: ignored while busy
  assign step_o = busy_q;
  assign last   = busy_q && (cnt_q == LAST_CNT);
  assign cnt_en = load_o || busy_q;

  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = last;
    if (load_o) begin
      cnt_n  = '0;
      busy_n = 1'b1;
    end else if (busy_q) begin
      cnt_n = cnt_q + 1'b1;
      if (last) begin
        busy_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      if (cnt_en) begin
        cnt_q <= cnt_n;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

endmodule

// File: rtl/booth4_mul.sv
module booth4_mul
  import booth4_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] product_o
);

  localparam int HW    = W + 2;
  localparam int STEPS = W / 2;

  logic           load, step, reg_en;
  logic [W-1:0]   mcand_q, mcand_n;
  logic [HW-1:0]  hi_q, hi_n;
  logic [W-1:0]   lo_q, lo_n;
  logic           xb_q, xb_n;
  logic [HW-1:0]  sum;
  booth_dig_e     dig;

  booth4_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .load_o  (load),
    .step_o  (step)
  );

  booth4_recoder u_rec (
    .win_i (({lo_q[1:0], xb_q})),
    .dig_o (dig)
  );

  booth4_addsub #(.W(W)) u_add (
    .mcand_i (mcand_q),
    .acc_i   (hi_q),
    .dig_o_i (dig),
    .sum_o   (sum)
  );

  assign reg_en = load || step;

  always_comb begin
    mcand_n = mcand_q;
    hi_n    = hi_q;
    lo_n    = lo_q;
    xb_n    = xb_q;
    if (load) begin
      mcand_n = mcand_i;
      hi_n    = '0;
      lo_n    = mplier_i;
      xb_n    = 1'b0;
    end else if (step) begin
      // add the selected multiple, then shift right by two keeping the sign
      hi_n = {{2{sum[HW-1]}}, sum[HW-1:2]};
      lo_n = {sum[1:0], lo_q[W-1:2]};
      xb_n = lo_q[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      xb_q    <= 1'b0;
    end else if (reg_en) begin
      mcand_q <= mcand_n;
      hi_q    <= hi_n;
      lo_q    <= lo_n;
      xb_q    <= xb_n;
    end
  end

  assign product_o = {hi_q[W-1:0], lo_q};

endmodule

// File: rtl/booth4_mul_chk.sv
module booth4_mul_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic [W-1:0]   mcand_i,
  input logic [W-1:0]   mplier_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [2*W-1:0] product_o
);

  localparam int STEPS = W / 2;
  localparam int KW    = $clog2(STEPS + 2) + 1;

  logic [KW-1:0]        busy_cnt;
  logic signed [W-1:0]  a_q, b_q;
  logic signed [2*W-1:0] ref_prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      a_q      <= '0;
      b_q      <= '0;
    end else if (start_i && !busy_o) begin
      busy_cnt <= '0;
      a_q      <= mcand_i;
      b_q      <= mplier_i;
    end else if (busy_o) begin
      busy_cnt <= busy_cnt + 1'b1;
    end
  end

  assign ref_prod = a_q * b_q;

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (busy_cnt == KW'(STEPS)));

  p_done_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (product_o == ref_prod));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(product_o));

  p_busy_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && busy_cnt < KW'(STEPS - 1)) |=> busy_o);

endmodule

bind booth4_mul booth4_mul_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .mcand_i   (mcand_i),
  .mplier_i  (mplier_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .product_o (product_o)
);

// File: tb/booth4_mul_tb.sv
module booth4_mul_tb;

  localparam int W     = 32;
  localparam int STEPS = W / 2;
  localparam int NV    = 12;

  // {multiplicand, multiplier}
  localparam logic [63:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'h0000_0001, 32'hFFFF_FFFF},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h8000_0000, 32'h8000_0000},
    {32'h8000_0000, 32'h7FFF_FFFF},
    {32'h7FFF_FFFF, 32'h7FFF_FFFF},
    {32'h8000_0000, 32'hFFFF_FFFF},
    {32'h1234_5678, 32'h9ABC_DEF0},
    {32'hFFFF_FFFF, 32'h5555_5555},
    {32'h0000_0006, 32'hAAAA_AAAA},
    {32'h7FFF_FFFF, 32'h8000_0000},
    {32'h0000_0003, 32'h0F0F_0F0F}
  };

  logic           clk;
  logic           rst_n;
  logic           start_i;
  logic [W-1:0]   mcand_i;
  logic [W-1:0]   mplier_i;
  logic           busy_o;
  logic           done_o;
  logic [2*W-1:0] product_o;

  int checks;
  int errors;
  int cycles;

  booth4_mul #(.W(W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sprod(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] r;
    r = $signed(a) * $signed(b);
    return r;
  endfunction

  // waits from the negedge after an accepted start until done; returns busy length
  task automatic wait_done(output int len);
    len = 0;
    while (busy_o && len < 100) begin
      len = len + 1;
      @(negedge clk);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input string req);
    int len;
    @(negedge clk);
    start_i  = 1'b1;
    mcand_i  = a;
    mplier_i = b;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(len);
    check(len == STEPS, {req, " R2 busy length"}, 64'(len), 64'(STEPS));
    check(done_o == 1'b1, {req, " R3 done"}, 64'(done_o), 64'd1);
    check(product_o == sprod(a, b), req, product_o, sprod(a, b));
  endtask

  initial begin
    int len;
    logic [63:0] held;
    checks   = 0;
    errors   = 0;
    cycles   = 0;
    rst_n    = 1'b0;
    start_i  = 1'b0;
    mcand_i  = '0;
    mplier_i = '0;
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0 && done_o == 1'b0, "R1 flags in reset",
          64'({busy_o, done_o}), 64'd0);
    check(product_o == '0, "R1 product in reset", product_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b0 && done_o == 1'b0 && product_o == '0,
          "R1 after release", product_o, 64'd0);

    // vector table: R4 main function, R7 digit patterns, R8 most negative
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][63:32], VEC[i][31:0], "R4 R7 R8 vector");
    end

    // R3 and R6: done drops, product held while idle, operands wiggling
    held = product_o;
    @(negedge clk);
    check(done_o == 1'b0, "R3 done single cycle", 64'(done_o), 64'd0);
    mcand_i  = 32'hDEAD_BEEF;
    mplier_i = 32'h0BAD_F00D;
    repeat (3) @(negedge clk);
    check(product_o == held, "R6 product held while idle", product_o, held);
    check(busy_o == 1'b0 && done_o == 1'b0, "R6 flags idle", 64'({busy_o, done_o}), 64'd0);

    // R5: start during busy is ignored
    @(negedge clk);
    start_i  = 1'b1;
    mcand_i  = 32'hFFFF_FFF9;
    mplier_i = 32'h0000_0011;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    start_i  = 1'b1;
    mcand_i  = 32'h7FFF_FFFF;
    mplier_i = 32'h7FFF_FFFF;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(len);
    check(len == STEPS - 4, "R5 length unchanged", 64'(len), 64'(STEPS - 4));
    check(product_o == sprod(32'hFFFF_FFF9, 32'h0000_0011), "R5 result unchanged",
          product_o, sprod(32'hFFFF_FFF9, 32'h0000_0011));

    // R9: start on the done cycle
    start_i  = 1'b1;
    mcand_i  = 32'h8000_0000;
    mplier_i = 32'h0000_0003;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R9 back-to-back accepted", 64'(busy_o), 64'd1);
    wait_done(len);
    check(len == STEPS, "R9 busy length", 64'(len), 64'(STEPS));
    check(product_o == sprod(32'h8000_0000, 32'h0000_0003), "R9 R8 result",
          product_o, sprod(32'h8000_0000, 32'h0000_0003));

    // R7: run boundaries at the top and bottom of the multiplier
    run_op(32'h0000_0007, 32'h8000_0001, "R7 edge runs");
    run_op(32'h8000_0000, 32'h6666_6666, "R7 R8 +/-2 digits");

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule